// File: doc/BRIEF.md
# Non-Temporal Hint Prefix Tracker

This block sits next to an in-order decoder. It watches each instruction for one of the non-temporal locality hints. Each hint is architecturally an ADD that writes register zero, so it does nothing to the register state. A recognised hint is held for one instruction in a small pending register. The next memory access picks it up, clears it, and turns it into per-level cache policy for a hierarchy with private L1, private L2 and a shared L3.

The policy arrives one cycle after the consuming instruction and has two forms:
- **Ordinary accesses:** a per-level allocate mask and a per-level insert-at-LRU mask.
- **Prefetches:** a target level, which lies further out than the level the hint names.

A traps or interrupt discards the pending hint. So does any plain instruction retiring between the hint and its target. This keeps the hint from ever reaching an unrelated instruction.

Top module: `ntl_prefix_tracker`

## Requirements
- R1: A 32-bit word is a hint only when opcode[6:0]=0110011, funct3=000, funct7=0, rd=0, rs1=0 and rs2 (bits 24:20) is 2, 3, 4 or 5. These map to level codes 0 (innermost private), 1 (all private), 2 (innermost shared) and 3 (all caches). Any other ADD is an ordinary instruction.
- R2: With `in_rvc`=1, the low half-word is a hint when bits[15:12]=1001, bits[11:7]=0, bits[1:0]=10 and bits[6:2] is 2 to 5. It gives the same level codes as R1.
- R3: A hint loads the pending state. The next consuming op takes it and clears it, so a second op right after is unhinted.
- R4: `trap` clears the pending state. Any instruction presented in the same cycle produces no policy and does not load a hint.
- R5: `irq` behaves like `trap`: it drops the pending hint, and the slot presented with it has no effect.
- R6: A plain instruction (class 0, not a hint) clears the pending hint. A cache-block management op (class 4) neither consumes nor clears it and produces no policy.
- R7: A hint decoded while another is pending replaces it.
- R8: With `lru_mode`=0, ordinary accesses (class 1) and block-zero ops (class 3) use these allocate masks (bit 0 is L1):
  - no hint: 111
  - code 0: 110
  - code 1: 100
  - codes 2 and 3: 000
  
  In this mode the LRU mask is 000.
- R9: With `lru_mode`=1, every level allocates (111). The LRU mask equals the suppressed set: 001, 011, 111, 111 for codes 0 to 3, and 000 with no hint.
- R10: A prefetch (class 2) reports target 0/1/2/3 (L1/L2/L3/memory buffer) for no hint, code 0, code 1, and codes 2 or 3. Its allocate mask is the one-hot of the target (000 for the memory buffer), and its LRU mask is 000.
- R11: A block-zero op carrying code 1 in `lru_mode`=0 allocates only in L3 (mask 100).
- R12: While reset is held, every output is 0 and no hint is pending.
- R13: Policy outputs are valid exactly one cycle after a consuming op (classes 1, 2, 3). In every other cycle all policy outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lru_mode | input | 1 | 1: suppressed levels insert at LRU; 0: suppressed levels skip allocation |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_instr | input | 32 | Instruction bits (low half used when compressed) |
| in_rvc | input | 1 | Instruction is 16-bit |
| in_class | input | 3 | 0 none, 1 access, 2 prefetch, 3 block zero, 4 block management |
| trap | input | 1 | Target instruction trapped |
| irq | input | 1 | Interrupt taken |
| pol_valid | output | 1 | Policy for the op of the previous cycle |
| pol_prefetch | output | 1 | That op was a prefetch |
| pol_hinted | output | 1 | A hint was applied |
| pol_hint | output | 2 | Applied level code |
| pol_alloc | output | LVLS (3) | Per-level allocate, bit 0 = L1 |
| pol_lru | output | LVLS (3) | Per-level insert-at-LRU |
| pol_pf_tgt | output | 2 | Prefetch target level, LVLS = memory buffer |

## Verification
On every cycle, the assertions check the pending-state rules:
- a flush empties the pending state;
- a hint loads its code;
- a consuming op leaves nothing pending;
- policy appears exactly one cycle after a consuming op.

They also check the shape of the output: prefetch masks are one-hot, and unhinted accesses allocate everywhere.

The exact per-code masks, the prefetch target table, and the compressed and non-hint ADD encodings are shown only by the bench. It runs ordered scenarios, compared every cycle against its own model. The same holds for the lifetime of a hint across management ops, plain instructions, overwrites and same-cycle traps.

// File: rtl/ntl_pkg.sv
package ntl_pkg;

  typedef enum logic [2:0] {
    MC_NONE     = 3'd0,
    MC_ACCESS   = 3'd1,
    MC_PREFETCH = 3'd2,
    MC_ZERO     = 3'd3,
    MC_MGMT     = 3'd4
  } memclass_e;

  typedef enum logic [1:0] {
    NT_PRIV1   = 2'd0,
    NT_PRIVALL = 2'd1,
    NT_SHARED1 = 2'd2,
    NT_ALL     = 2'd3
  } ntl_e;

  typedef struct packed {
    logic valid;
    ntl_e lvl;
  } hint_t;

  // 32-bit form: ADD x0, x0, x2..x5
  function automatic hint_t match_wide(input logic [31:0] w);
    hint_t r;
    logic [4:0] src;
    logic [4:0] off;
    src = w[24:20];
    off = src - 5'd2;
    r.valid = (w[6:0] == 7'b0110011) && (w[14:12] == 3'b000) &&
              (w[31:25] == 7'd0) && (w[11:7] == 5'd0) &&
              (w[19:15] == 5'd0) && (src >= 5'd2) && (src <= 5'd5);
    r.lvl = ntl_e'(off[1:0]);
    return r;
  endfunction

  // 16-bit form: C.ADD x0, x2..x5
  function automatic hint_t match_narrow(input logic [15:0] h);
    hint_t r;
    logic [4:0] src;
    logic [4:0] off;
    src = h[6:2];
    off = src - 5'd2;
    r.valid = (h[15:12] == 4'b1001) && (h[11:7] == 5'd0) &&
              (h[1:0] == 2'b10) && (src >= 5'd2) && (src <= 5'd5);
    r.lvl = ntl_e'(off[1:0]);
    return r;
  endfunction

  // Number of levels (from the innermost) in which locality is denied.
  function automatic int unsigned deny_depth(input ntl_e l, input int unsigned lvls,
                                             input int unsigned shared_lvl);
    case (l)
      NT_PRIV1:   return 1;
      NT_PRIVALL: return shared_lvl - 1;
      NT_SHARED1: return shared_lvl;
      default:    return lvls;
    endcase
  endfunction

  // Prefetch destination: one level beyond the denied ones; lvls = memory buffer.
  function automatic int unsigned pf_level(input logic hinted, input int unsigned depth,
                                           input int unsigned lvls);
    if (!hinted) return 0;
    return (depth >= lvls) ? lvls : depth;
  endfunction

endpackage

// File: rtl/ntl_hint_decode.sv
module ntl_hint_decode
  import ntl_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        rvc,
  output hint_t       hit
);
  hint_t wide_h;
  hint_t narrow_h;

  always_comb begin
    wide_h   = match_wide(instr);
    narrow_h = match_narrow(instr[15:0]);
    hit      = rvc ? narrow_h : wide_h;
  end
endmodule

// File: rtl/ntl_pending.sv
module ntl_pending
  import ntl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  load,
  input  ntl_e  load_lvl,
  input  logic  drop,
  output hint_t pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (flush) begin
      pend <= '0;
    end else if (load) begin
      pend.valid <= 1'b1;
      pend.lvl   <= load_lvl;
    end else if (drop) begin
      pend <= '0;
    end
  end
endmodule

// File: rtl/ntl_policy_map.sv
module ntl_policy_map
  import ntl_pkg::*;
#(
  parameter int LVLS       = 3,
  parameter int SHARED_LVL = 3,
  localparam int TGT_W     = $clog2(LVLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_pf,
  input  hint_t            pend,
  input  logic             lru_mode,
  output logic             pol_valid,
  output logic             pol_prefetch,
  output logic             pol_hinted,
  output logic [1:0]       pol_hint,
  output logic [LVLS-1:0]  pol_alloc,
  output logic [LVLS-1:0]  pol_lru,
  output logic [TGT_W-1:0] pol_pf_tgt
);
  int unsigned       depth;
  int unsigned       tgt_i;
  logic [TGT_W-1:0]  tgt_n;
  logic [LVLS-1:0]   deny;
  logic [LVLS-1:0]   alloc_n;
  logic [LVLS-1:0]   lru_n;
  logic [LVLS-1:0]   pf_oh;

  always_comb begin
    depth = deny_depth(pend.lvl, LVLS, SHARED_LVL);
    tgt_i = pf_level(pend.valid, depth, LVLS);
    tgt_n = tgt_i[TGT_W-1:0];
  end

  for (genvar i = 0; i < LVLS; i++) begin : g_lvl
    assign deny[i]    = pend.valid && (depth > i);
    assign alloc_n[i] = lru_mode | ~deny[i];
    assign lru_n[i]   = lru_mode & deny[i];
    assign pf_oh[i]   = (tgt_n == TGT_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fire) begin
      pol_valid    <= 1'b0;
      pol_prefetch <= 1'b0;
      pol_hinted   <= 1'b0;
      pol_hint     <= '0;
      pol_alloc    <= '0;
      pol_lru      <= '0;
      pol_pf_tgt   <= '0;
    end else begin
      pol_valid    <= 1'b1;
      pol_prefetch <= is_pf;
      pol_hinted   <= pend.valid;
      pol_hint     <= pend.valid ? pend.lvl : 2'd0;
      pol_alloc    <= is_pf ? pf_oh : alloc_n;
      pol_lru      <= is_pf ? '0 : lru_n;
      pol_pf_tgt   <= is_pf ? tgt_n : '0;
    end
  end
endmodule

// File: rtl/ntl_prefix_tracker.sv
module ntl_prefix_tracker
  import ntl_pkg::*;
#(
  parameter int LVLS       = 3,
  parameter int SHARED_LVL = 3,
  localparam int TGT_W     = $clog2(LVLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lru_mode,
  input  logic             in_valid,
  input  logic [31:0]      in_instr,
  input  logic             in_rvc,
  input  logic [2:0]       in_class,
  input  logic             trap,
  input  logic             irq,
  output logic             pol_valid,
  output logic             pol_prefetch,
  output logic             pol_hinted,
  output logic [1:0]       pol_hint,
  output logic [LVLS-1:0]  pol_alloc,
  output logic [LVLS-1:0]  pol_lru,
  output logic [TGT_W-1:0] pol_pf_tgt
);
  hint_t     dec_hit;
  hint_t     pend;
  memclass_e cls;
  logic      flush;
  logic      slot;
  logic      hint_hit;
  logic      consume;
  logic      plain_ret;
  logic      is_pf;

  assign cls       = memclass_e'(in_class);
  assign flush     = trap | irq;
  assign slot      = in_valid & ~flush;
  assign hint_hit  = slot & dec_hit.valid;
  assign consume   = slot & ~dec_hit.valid &
                     ((cls == MC_ACCESS) | (cls == MC_PREFETCH) | (cls == MC_ZERO));
  assign plain_ret = slot & ~dec_hit.valid & (cls == MC_NONE);
  assign is_pf     = (cls == MC_PREFETCH);

  ntl_hint_decode u_dec (
    .instr (in_instr),
    .rvc   (in_rvc),
    .hit   (dec_hit)
  );

  ntl_pending u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (hint_hit),
    .load_lvl (dec_hit.lvl),
    .drop     (consume | plain_ret),
    .pend     (pend)
  );

  ntl_policy_map #(.LVLS(LVLS), .SHARED_LVL(SHARED_LVL)) u_map (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (consume),
    .is_pf        (is_pf),
    .pend         (pend),
    .lru_mode     (lru_mode),
    .pol_valid    (pol_valid),
    .pol_prefetch (pol_prefetch),
    .pol_hinted   (pol_hinted),
    .pol_hint     (pol_hint),
    .pol_alloc    (pol_alloc),
    .pol_lru      (pol_lru),
    .pol_pf_tgt   (pol_pf_tgt)
  );
endmodule

// File: rtl/ntl_chk.sv
module ntl_chk #(
  parameter int LVLS = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            hint_hit,
  input logic [1:0]      hint_lvl,
  input logic            consume,
  input logic            pend_valid,
  input logic [1:0]      pend_lvl,
  input logic            pol_valid,
  input logic            pol_prefetch,
  input logic            pol_hinted,
  input logic [LVLS-1:0] pol_alloc,
  input logic [LVLS-1:0] pol_lru
);
  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_valid);

  // R7
  hint_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hint_hit |=> (pend_valid && pend_lvl == $past(hint_lvl)));

  // R3
  consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !pend_valid);

  // R13
  policy_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> pol_valid);

  // R13
  no_stray_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !consume |=> !pol_valid);

  // R10
  pf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_valid && pol_prefetch) |-> ($onehot0(pol_alloc) && pol_lru == '0));

  // R8
  unhinted_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_valid && !pol_hinted && !pol_prefetch) |-> (&pol_alloc && pol_lru == '0));
endmodule

bind ntl_prefix_tracker ntl_chk #(.LVLS(LVLS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flush        (flush),
  .hint_hit     (hint_hit),
  .hint_lvl     (dec_hit.lvl),
  .consume      (consume),
  .pend_valid   (pend.valid),
  .pend_lvl     (pend.lvl),
  .pol_valid    (pol_valid),
  .pol_prefetch (pol_prefetch),
  .pol_hinted   (pol_hinted),
  .pol_alloc    (pol_alloc),
  .pol_lru      (pol_lru)
);

// File: tb/sim_ntl_prefix_tracker.sv
module sim_ntl_prefix_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lru_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic       in_rvc = 1'b0;
  logic [2:0] in_class = '0;
  logic       trap = 1'b0;
  logic       irq = 1'b0;
  logic       pol_valid, pol_prefetch, pol_hinted;
  logic [1:0] pol_hint, pol_pf_tgt;
  logic [2:0] pol_alloc, pol_lru;

  int vectors = 0;
  int errors  = 0;
  int mp = -1;                       // model pending code, -1 = none
  logic [12:0] exp_v = '0;           // {valid,pf,hinted,hint[1:0],alloc[2:0],lru[2:0],tgt[1:0]}

  always #5 clk = ~clk;

  ntl_prefix_tracker u0 (
    .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode), .in_valid(in_valid),
    .in_instr(in_instr), .in_rvc(in_rvc), .in_class(in_class), .trap(trap), .irq(irq),
    .pol_valid(pol_valid), .pol_prefetch(pol_prefetch), .pol_hinted(pol_hinted),
    .pol_hint(pol_hint), .pol_alloc(pol_alloc), .pol_lru(pol_lru), .pol_pf_tgt(pol_pf_tgt)
  );

  function automatic logic [31:0] w32(input int k);
    logic [4:0] r = k[4:0];
    return {7'd0, r, 5'd0, 3'd0, 5'd0, 7'b0110011};
  endfunction

  function automatic logic [31:0] w16(input int k);
    logic [4:0] r = k[4:0];
    return {16'h0, 4'b1001, 5'd0, r, 2'b10};
  endfunction

  function automatic int bench_hint(input logic [31:0] w, input logic c);
    for (int k = 2; k <= 5; k++) begin
      if (!c && w == w32(k)) return k - 2;
      if (c && w[15:0] == w16(k) [15:0]) return k - 2;
    end
    return -1;
  endfunction

  task automatic compare(input string req);
    logic [12:0] got;
    got = {pol_valid, pol_prefetch, pol_hinted, pol_hint, pol_alloc, pol_lru, pol_pf_tgt};
    vectors++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp_v);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, input logic c,
                      input int cls, input logic tr, input logic ir,
                      input logic lm, input string req);
    int h;
    logic [2:0] a, l;
    logic [1:0] t;
    in_valid = v; in_instr = ins; in_rvc = c; in_class = cls[2:0];
    trap = tr; irq = ir; lru_mode = lm;
    exp_v = '0;
    h = bench_hint(ins, c);
    if (tr || ir) mp = -1;
    else if (v && h >= 0) mp = h;
    else if (v && cls == 0) mp = -1;
    else if (v && (cls == 1 || cls == 3)) begin
      case (mp)
        -1: begin a = 3'b111; l = 3'b000; end
        0:  begin a = lm ? 3'b111 : 3'b110; l = lm ? 3'b001 : 3'b000; end
        1:  begin a = lm ? 3'b111 : 3'b100; l = lm ? 3'b011 : 3'b000; end
        default: begin a = lm ? 3'b111 : 3'b000; l = lm ? 3'b111 : 3'b000; end
      endcase
      exp_v = {1'b1, 1'b0, mp >= 0, (mp >= 0) ? mp[1:0] : 2'd0, a, l, 2'd0};
      mp = -1;
    end else if (v && cls == 2) begin
      case (mp)
        -1: begin t = 2'd0; a = 3'b001; end
        0:  begin t = 2'd1; a = 3'b010; end
        1:  begin t = 2'd2; a = 3'b100; end
        default: begin t = 2'd3; a = 3'b000; end
      endcase
      exp_v = {1'b1, 1'b1, mp >= 0, (mp >= 0) ? mp[1:0] : 2'd0, a, 3'b000, t};
      mp = -1;
    end
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, got=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R12 reset state
    in_valid = 1'b1; in_instr = w32(2); in_class = 3'd1;
    repeat (3) @(negedge clk);
    exp_v = '0; compare("R12");
    in_valid = 1'b0;
    rst_n = 1'b1;
    step(0, '0, 0, 1, 0, 0, 0, "R12");
    step(1, '0, 0, 1, 0, 0, 0, "R13");
    // R1 32-bit hints, each consumed by an access (R8 bypass)
    for (int k = 2; k <= 5; k++) begin
      step(1, w32(k), 0, 0, 0, 0, 0, "R1");
      step(1, '0, 0, 1, 0, 0, 0, "R8");
    end
    // R1 non-hint ADDs
    step(1, w32(6), 0, 0, 0, 0, 0, "R1");
    step(1, '0, 0, 1, 0, 0, 0, "R1");
    step(1, w32(2) | 32'h0000_0080, 0, 0, 0, 0, 0, "R1");
    step(1, '0, 0, 1, 0, 0, 0, "R1");
    // R2 compressed hints, consumed in LRU mode (R9)
    for (int k = 2; k <= 5; k++) begin
      step(1, w16(k), 1, 0, 0, 0, 1, "R2");
      step(1, '0, 0, 1, 0, 0, 1, "R9");
    end
    step(1, w16(6), 1, 0, 0, 0, 1, "R2");
    step(1, '0, 0, 1, 0, 0, 1, "R2");
    // R3 second op unhinted
    step(1, w32(3), 0, 0, 0, 0, 0, "R3");
    step(1, '0, 0, 1, 0, 0, 0, "R3");
    step(1, '0, 0, 1, 0, 0, 0, "R3");
    // R4 trap in the target cycle and with a hint
    step(1, w32(4), 0, 0, 0, 0, 0, "R4");
    step(1, '0, 0, 1, 1, 0, 0, "R4");
    step(1, '0, 0, 1, 0, 0, 0, "R4");
    step(1, w32(5), 0, 0, 1, 0, 0, "R4");
    step(1, '0, 0, 1, 0, 0, 0, "R4");
    // R5 interrupt between hint and target
    step(1, w32(2), 0, 0, 0, 0, 0, "R5");
    step(0, '0, 0, 0, 0, 1, 0, "R5");
    step(1, '0, 0, 1, 0, 0, 0, "R5");
    // R6 plain retire clears; management op passes through
    step(1, w32(2), 0, 0, 0, 0, 0, "R6");
    step(1, 32'h0020_8093, 0, 0, 0, 0, 0, "R6");
    step(1, '0, 0, 1, 0, 0, 0, "R6");
    step(1, w32(3), 0, 0, 0, 0, 0, "R6");
    step(1, '0, 0, 4, 0, 0, 0, "R6");
    step(1, '0, 0, 1, 0, 0, 0, "R6");
    // R7 overwrite
    step(1, w32(2), 0, 0, 0, 0, 0, "R7");
    step(1, w16(5), 1, 0, 0, 0, 0, "R7");
    step(1, '0, 0, 1, 0, 0, 0, "R7");
    // R10 prefetch targets
    step(1, '0, 0, 2, 0, 0, 0, "R10");
    for (int k = 2; k <= 5; k++) begin
      step(1, w32(k), 0, 0, 0, 0, 0, "R10");
      step(1, '0, 0, 2, 0, 0, k[0], "R10");
    end
    // R11 block zero with all-private hint
    step(1, w32(3), 0, 0, 0, 0, 0, "R11");
    step(1, '0, 0, 3, 0, 0, 0, "R11");
    step(1, '0, 0, 3, 0, 0, 0, "R11");
    step(0, '0, 0, 0, 0, 0, 0, "R13");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule